// File: doc/BRIEF.md
# DMA Bus Arbiter with Session Time-out

This block decides when an external DMA master may drive the system bus. The processor always has the lowest priority, so a DMA request is served whenever it is raised. In normal operation the arbiter asks the processor interface to give up the bus with a hold request. It issues the grant only after the processor answers with a hold acknowledge at the end of its current access. When the processor is in power-down its bus is already floating, so the grant follows the request with no acknowledge.

Each DMA session is limited by a programmable cycle count. When the count runs out, the grant is withdrawn and a one-cycle time-out error pulse is raised. The master must then drop its request before it can be granted again. A limit of zero means no limit under the default configuration. The limit input must be held stable while a session is running.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dma_grant`, `hold_req` and `timeout_err` are all low.
- R2: With `pwr_down` low, a request raised in the idle state asserts `hold_req` one cycle later, and `dma_grant` stays low until `hold_ack` has been seen.
- R3: `hold_ack` sampled high while waiting raises `dma_grant` on the next cycle, and `hold_req` stays high for the whole grant.
- R4: With `pwr_down` high, a pending request is granted one cycle later with no `hold_ack`. This applies both from idle and from the waiting state.
- R5: Dropping `dma_req` while waiting or while granted drops `dma_grant` and `hold_req` on the next cycle.
- R6: With `session_limit` = L (1 to 65535), `dma_grant` stays high for exactly L consecutive cycles of one session and then falls, even if `dma_req` is still high.
- R7: On the first cycle that `dma_grant` is low after an expiry, `timeout_err` is high for exactly that one cycle, and `hold_req` is low.
- R8: After a time-out, no new grant is given while `dma_req` stays high. Once `dma_req` has been low for one cycle, a new request is served normally.
- R9: With `session_limit` = 0 and `ZERO_UNLIMITED` = 1 (the default), a session never times out.
- R10: `hold_ack` raised while no request is pending has no effect: all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | 1 | Bus request from the DMA master |
| pwr_down | input | 1 | Processor is in power-down and its bus is floating |
| hold_ack | input | 1 | Processor bus interface has released the bus |
| session_limit | input | CNT_W | Maximum grant length in cycles; 0 = unlimited by default |
| dma_grant | output | 1 | Bus granted to the DMA master |
| hold_req | output | 1 | Request to the processor to release the bus |
| timeout_err | output | 1 | One-cycle pulse when a session exceeds its limit |

## Verification
A vector sequence walks the arbiter through request, wait, acknowledge, grant, expiry and release. The same request is tried with the acknowledge held back, given at once, and replaced by power-down, which separates the handshake path from the direct path. Requests withdrawn while waiting and while granted show that release does not depend on the state. Limits of 1, 300 and 0 separate an off-by-one in the session counter from the unlimited mode. A request held high across an expiry shows that re-grant is blocked until the request drops.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_ACK = 2'd1,
      ST_GRANTED  = 2'd2,
      ST_TIMEOUT  = 2'd3
   } arb_state_t;

endpackage

// File: rtl/dma_arb_timer.sv
module dma_arb_timer #(
   parameter int CNT_W          = 16,
   parameter bit ZERO_UNLIMITED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);

   localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] CNT_ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic             last_cycle;

   // cycles already spent in the current grant; cleared outside a grant
   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= CNT_ZERO;
      else if (run_i)  cnt_q <= cnt_q + CNT_ONE;
      else             cnt_q <= CNT_ZERO;
   end

   assign last_cycle = (cnt_q == (limit_i - CNT_ONE));

   generate
      if (ZERO_UNLIMITED) begin : g_zero_off
         // limit 0 disables the session time-out
         assign expire_o = run_i && (limit_i != CNT_ZERO) && last_cycle;

         AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (run_i && limit_i != CNT_ZERO && $stable(limit_i)) |-> (cnt_q < limit_i)); // R6
      end else begin : g_zero_full
         // limit 0 wraps to the full counter range
         assign expire_o = run_i && last_cycle;
      end
   endgenerate

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
   import dma_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic dma_req,
   input  logic pwr_down,
   input  logic hold_ack,
   input  logic expire_i,
   output logic granted_o,
   output logic hold_req,
   output logic timeout_err
);

   arb_state_t state_q, state_d;
   logic       to_pulse_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (dma_req) state_d = pwr_down ? ST_GRANTED : ST_WAIT_ACK;
         end
         ST_WAIT_ACK: begin
            if (!dma_req)                 state_d = ST_IDLE;
            else if (hold_ack || pwr_down) state_d = ST_GRANTED;
         end
         ST_GRANTED: begin
            if (!dma_req)      state_d = ST_IDLE;
            else if (expire_i) state_d = ST_TIMEOUT;
         end
         ST_TIMEOUT: begin
            if (!dma_req) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         to_pulse_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         to_pulse_q <= (state_q == ST_GRANTED) && (state_d == ST_TIMEOUT);
      end
   end

   assign granted_o   = (state_q == ST_GRANTED);
   assign hold_req    = (state_q == ST_WAIT_ACK) || (state_q == ST_GRANTED);
   assign timeout_err = to_pulse_q;

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      granted_o |-> $past(dma_req)); // R5
   AST_GRANT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(granted_o) |-> $past(hold_ack || pwr_down)); // R2
   AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_req && !dma_req) |=> (!granted_o && !hold_req)); // R5
   AST_TO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |=> !timeout_err); // R7
   AST_TO_ENDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_err |-> (!granted_o && !hold_req && $past(granted_o))); // R7
   AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_err && dma_req) |=> !granted_o); // R8

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
   parameter int CNT_W          = 16,
   parameter bit ZERO_UNLIMITED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_req,
   input  logic             pwr_down,
   input  logic             hold_ack,
   input  logic [CNT_W-1:0] session_limit,
   output logic             dma_grant,
   output logic             hold_req,
   output logic             timeout_err
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("dma_bus_arbiter: CNT_W must lie in 2..32");
      end
   endgenerate

   logic granted;
   logic expire;

   dma_arb_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .dma_req     (dma_req),
      .pwr_down    (pwr_down),
      .hold_ack    (hold_ack),
      .expire_i    (expire),
      .granted_o   (granted),
      .hold_req    (hold_req),
      .timeout_err (timeout_err)
   );

   dma_arb_timer #(
      .CNT_W          (CNT_W),
      .ZERO_UNLIMITED (ZERO_UNLIMITED)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (granted),
      .limit_i  (session_limit),
      .expire_o (expire)
   );

   assign dma_grant = granted;

   AST_GRANT_HAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dma_grant |-> hold_req); // R3
   AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_req && !dma_grant && !dma_req) |=> (!hold_req && !dma_grant)); // R10

endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dma_req = 1'b0;
   logic        pwr_down = 1'b0;
   logic        hold_ack = 1'b0;
   logic [15:0] session_limit = 16'd3;
   logic        dma_grant, hold_req, timeout_err;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   always #10 clk = ~clk; // 50 MHz

   dma_bus_arbiter dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .dma_req       (dma_req),
      .pwr_down      (pwr_down),
      .hold_ack      (hold_ack),
      .session_limit (session_limit),
      .dma_grant     (dma_grant),
      .hold_req      (hold_req),
      .timeout_err   (timeout_err)
   );

   // vector: {pwr_down, dma_req, hold_ack, exp_grant, exp_hold, exp_to, req_tag[3:0]}
   localparam logic [9:0] VEC [16] = '{
      {3'b000, 3'b000, 4'd1},  // R1 idle stays idle
      {3'b010, 3'b010, 4'd2},  // R2 hold request, no grant
      {3'b010, 3'b010, 4'd2},  // R2 still waiting
      {3'b011, 3'b110, 4'd3},  // R3 ack gives grant
      {3'b011, 3'b110, 4'd6},  // R6 grant cycle 2
      {3'b010, 3'b110, 4'd6},  // R6 grant cycle 3
      {3'b010, 3'b001, 4'd7},  // R7 expiry pulse
      {3'b010, 3'b000, 4'd8},  // R8 held request blocked
      {3'b000, 3'b000, 4'd8},  // R8 request dropped
      {3'b110, 3'b110, 4'd4},  // R4 power-down direct grant
      {3'b100, 3'b000, 4'd5},  // R5 release from grant
      {3'b010, 3'b010, 4'd2},  // R2 wait again
      {3'b000, 3'b000, 4'd5},  // R5 withdraw while waiting
      {3'b010, 3'b010, 4'd2},  // R2 wait
      {3'b110, 3'b110, 4'd4},  // R4 power-down while waiting
      {3'b000, 3'b000, 4'd5}   // R5 release
   };

   task automatic check(input logic [2:0] act, input logic [2:0] exp, input int tag);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL R%0d: {grant,hold,to} actual %b expected %b at t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [2:0] outs();
      return {dma_grant, hold_req, timeout_err};
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int gcount;
      logic ok;
      @(negedge clk);
      step();
      check(outs(), 3'b000, 1); // R1 during reset
      rst_n = 1'b1;
      step();
      check(outs(), 3'b000, 1); // R1 after reset

      // vector walk, limit 3
      session_limit = 16'd3;
      for (int i = 0; i < 16; i++) begin
         {pwr_down, dma_req, hold_ack} = VEC[i][9:7];
         step();
         check(outs(), VEC[i][6:4], int'(VEC[i][3:0]));
      end
      {pwr_down, dma_req, hold_ack} = 3'b000;

      // R10: acknowledge with no request
      hold_ack = 1'b1;
      step();
      check(outs(), 3'b000, 10);
      step();
      check(outs(), 3'b000, 10);
      hold_ack = 1'b0;

      // R6/R7/R8: limit 1
      session_limit = 16'd1;
      pwr_down = 1'b1; dma_req = 1'b1;
      step();
      check(outs(), 3'b110, 6);
      step();
      check(outs(), 3'b001, 7);
      step();
      check(outs(), 3'b000, 8);
      dma_req = 1'b0;
      step();
      check(outs(), 3'b000, 8);
      dma_req = 1'b1;
      step();
      check(outs(), 3'b110, 8); // R8 re-grant after drop
      dma_req = 1'b0; pwr_down = 1'b0;
      step();

      // R9: limit 0 means unlimited
      session_limit = 16'd0;
      pwr_down = 1'b1; dma_req = 1'b1;
      ok = 1'b1;
      for (int k = 0; k < 80; k++) begin
         step();
         if (!dma_grant || timeout_err) ok = 1'b0;
      end
      check({ok, 2'b00}, 3'b100, 9);
      dma_req = 1'b0; pwr_down = 1'b0;
      step();
      check(outs(), 3'b000, 5);

      // R6: limit 300 through the handshake path
      session_limit = 16'd300;
      dma_req = 1'b1; hold_ack = 1'b1;
      step();
      check(outs(), 3'b010, 2);
      step();
      gcount = 0;
      while (dma_grant && gcount < 1000) begin
         gcount++;
         step();
      end
      check(gcount[2:0] == 3'(300 % 8) && gcount == 300 ? 3'b001 : 3'b000, 3'b001, 6);
      if (gcount != 300) $display("FAIL R6: grant length actual %0d expected 300", gcount);
      check(outs(), 3'b001, 7);
      dma_req = 1'b0; hold_ack = 1'b0;
      step();
      check(outs(), 3'b000, 8);

      // R1: reset in the middle of a grant
      pwr_down = 1'b1; dma_req = 1'b1; session_limit = 16'd50;
      step();
      check(outs(), 3'b110, 4);
      rst_n = 1'b0;
      step();
      check(outs(), 3'b000, 1);
      dma_req = 1'b0; pwr_down = 1'b0;
      rst_n = 1'b1;
      step();
      check(outs(), 3'b000, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule